// File: doc/BRIEF.md
# Module Presence-Detect EEPROM Target

This block is a two-wire bus target that behaves like the configuration EEPROM found on a memory module. It holds a 256-byte array and answers on the bus at a seven-bit address made of a four-bit device-type code in the upper bits and the three slot-select pins in the lower bits. Up to eight modules can therefore share one bus. The block supports three transactions on the array: a byte write, a random read, and a current-address sequential read. The first byte after a START carries the seven-bit address and a read/write bit.

A second device-type code is a protection control. Addressing it sets a sticky write-protect, after which the array ignores writes. An optional third code returns a fixed sensor register value. Both bus lines are sampled with the system clock through synchronizers, and the data line is driven only through an open-drain enable.

A status output reports whether the checksum byte at offset 63 equals the low eight bits of the plain, non-negated sum of bytes 0 to 62. The flag is re-evaluated after reset and after every accepted array write.

Top module: `spdTarget`

## Requirements
- R1: After reset the block releases the data line (sdaOe low), the array reads as all zero, and csumOk rises within 100 clocks because a zero array carries a valid checksum.
- R2: An address byte whose upper four bits are 1010 and whose lower three bits equal slotSel is acknowledged. Any other slot or an unknown type code is left unacknowledged, and the data line stays released until the next START or STOP.
- R3: In a write to the array, the first data byte loads the byte pointer. Each later data byte is stored at the pointer, the pointer then advances by one, and every data byte is acknowledged.
- R4: A random read (write of one pointer byte, a repeated START, then the read address) returns the stored bytes from that pointer onward, most significant bit first, for as long as the master acknowledges.
- R5: A read that begins without a pointer byte continues from the pointer left by the previous access.
- R6: The pointer wraps from 255 to 0 on both writes and reads.
- R7: Type code 0011 with a matching slot is acknowledged only while the block is unprotected, and accessing it sets write-protect until reset. While protected, array data bytes are still acknowledged and still advance the pointer, but the stored contents do not change.
- R8: When the sensor option is enabled, type code 0001 with a matching slot is acknowledged, and every byte read from it is the fixed parameter value TEMP_VAL.
- R9: csumOk is 1 exactly when byte 63 equals bits 7:0 of the sum of bytes 0 to 62. It settles within 100 clocks after the STOP of a write.
- R10: A master that does not acknowledge a read byte ends the read. The data line then stays released until STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| slotSel | input | 3 | Slot-select pins forming the low address bits |
| sdaOe | output | 1 | Pulls the data line low when 1 |
| csumOk | output | 1 | Stored checksum matches the computed one |

## Verification
The hardest state to reach from the ports is a protected array that still acknowledges writes while its contents stay frozen. A second hard case is the checksum flag falling and rising again as bytes below offset 63 are changed. The stimulus first writes across the 255-to-0 wrap, so that byte 0 changes and the checksum breaks. It then writes the corrected sum into byte 63. Only after that does it touch the protection address, write a new value, and read back the old one. A behavioural model of the array and pointer predicts every acknowledge and data bit, and a per-clock monitor requires the data line to stay released after any refused address or master NACK.

// File: rtl/spdPkg.sv
package spdPkg;
  typedef struct packed {
    logic loadPtr;
    logic storeByte;
    logic stepPtr;
    logic setProt;
  } spdStrobe_t;

  typedef enum logic [1:0] {TGT_NONE, TGT_ARRAY, TGT_PROT, TGT_TEMP} spdTarget_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_IGNORE
  } spdState_e;
endpackage

// File: rtl/spdSync.sv
module spdSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spdCtrl.sv
module spdCtrl
  import spdPkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          SLOT_W   = 3,
  parameter logic [3:0]  ARR_CODE = 4'b1010,
  parameter logic [3:0]  PRT_CODE = 4'b0011,
  parameter logic [3:0]  TMP_CODE = 4'b0001,
  parameter bit          TEMP_EN  = 1'b1,
  parameter logic [7:0]  TEMP_VAL = 8'hC5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sda,
  input  logic [SLOT_W-1:0] slotSel,
  input  logic              isProt,
  input  logic [DATA_W-1:0] rdByte,
  output logic              sdaOe,
  output spdStrobe_t        strobe,
  output logic [DATA_W-1:0] wrByte
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

  spdState_e         state;
  spdTarget_e        tgt, hit;
  logic              sclQ, sdaQ, isRead, firstData, masterAck;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg, txShift, srcByte;

  wire sclRise = scl & ~sclQ;
  wire sclFall = ~scl & sclQ;
  wire startEv = scl & sclQ & sdaQ & ~sda;
  wire stopEv  = scl & sclQ & ~sdaQ & sda;

  always_comb begin
    hit = TGT_NONE;
    if (shiftReg[SLOT_W:1] == slotSel) begin
      if (shiftReg[DATA_W-1:DATA_W-4] == ARR_CODE)                    hit = TGT_ARRAY;
      else if (shiftReg[DATA_W-1:DATA_W-4] == PRT_CODE && !isProt)    hit = TGT_PROT;
      else if (TEMP_EN && shiftReg[DATA_W-1:DATA_W-4] == TMP_CODE)    hit = TGT_TEMP;
    end
  end

  always_comb begin
    case (tgt)
      TGT_ARRAY: srcByte = rdByte;
      TGT_TEMP:  srcByte = DATA_W'(TEMP_VAL);
      default:   srcByte = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1; sdaQ <= 1'b1;
    end else begin
      sclQ <= scl; sdaQ <= sda;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; tgt <= TGT_NONE; sdaOe <= 1'b0; bitCnt <= '0;
      shiftReg <= '0; txShift <= '0; isRead <= 1'b0; firstData <= 1'b0;
      masterAck <= 1'b0; strobe <= '0; wrByte <= '0;
    end else begin
      strobe <= '0;
      if (startEv) begin
        state <= ST_ADDR; bitCnt <= '0; sdaOe <= 1'b0;
      end else if (stopEv) begin
        state <= ST_IDLE; sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[DATA_W-2:0], sda}; bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL) begin
              if (hit != TGT_NONE) begin
                tgt <= hit; isRead <= shiftReg[0]; sdaOe <= 1'b1;
                strobe.setProt <= (hit == TGT_PROT);
                state <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: if (sclFall) begin
            bitCnt <= '0; firstData <= 1'b1;
            if (isRead) begin
              sdaOe <= ~srcByte[DATA_W-1]; txShift <= {srcByte[DATA_W-2:0], 1'b0};
              state <= ST_RD;
            end else begin
              sdaOe <= 1'b0; state <= ST_WR;
            end
          end
          ST_WR: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[DATA_W-2:0], sda}; bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL) begin
              sdaOe <= 1'b1; firstData <= 1'b0; wrByte <= shiftReg;
              if (tgt == TGT_ARRAY) begin
                strobe.loadPtr   <= firstData;
                strobe.storeByte <= ~firstData;
              end
              state <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: if (sclFall) begin
            sdaOe <= 1'b0; bitCnt <= '0; state <= ST_WR;
          end
          ST_RD: if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              sdaOe <= 1'b0; strobe.stepPtr <= (tgt == TGT_ARRAY); state <= ST_RD_ACK;
            end else begin
              sdaOe <= ~txShift[DATA_W-1]; txShift <= {txShift[DATA_W-2:0], 1'b0};
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (sclRise) masterAck <= ~sda;
            else if (sclFall) begin
              if (masterAck) begin
                sdaOe <= ~srcByte[DATA_W-1]; txShift <= {srcByte[DATA_W-2:0], 1'b0};
                bitCnt <= '0; state <= ST_RD;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spdData.sv
module spdData
  import spdPkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int DATA_W   = 8,
  parameter int CSUM_POS = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  spdStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrByte,
  output logic [DATA_W-1:0] rdByte,
  output logic [$clog2(DEPTH)-1:0] curPtr,
  output logic              isProt,
  output logic              csumOk
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] CSUM_AT = PTR_W'(CSUM_POS);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr, walkIdx;
  logic [DATA_W-1:0] acc;
  logic              prot, walking;

  wire restart = strobe.storeByte & ~prot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr <= '0; prot <= 1'b0;
    end else begin
      if (strobe.loadPtr) ptr <= wrByte[PTR_W-1:0];
      if (strobe.storeByte) begin
        if (!prot) mem[ptr] <= wrByte;
        ptr <= ptr + 1'b1;
      end
      if (strobe.stepPtr) ptr <= ptr + 1'b1;
      if (strobe.setProt) prot <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walking <= 1'b1; walkIdx <= '0; acc <= '0; csumOk <= 1'b0;
    end else if (restart) begin
      walking <= 1'b1; walkIdx <= '0; acc <= '0;
    end else if (walking) begin
      if (walkIdx == CSUM_AT) begin
        csumOk  <= (acc == mem[CSUM_AT]);
        walking <= 1'b0;
      end else begin
        acc     <= acc + mem[walkIdx];
        walkIdx <= walkIdx + 1'b1;
      end
    end
  end

  assign rdByte = mem[ptr];
  assign curPtr = ptr;
  assign isProt = prot;
endmodule

// File: rtl/spdTarget.sv
module spdTarget
  import spdPkg::*;
#(
  parameter int         DEPTH       = 256,
  parameter int         SYNC_STAGES = 2,
  parameter bit         TEMP_EN     = 1'b1,
  parameter logic [7:0] TEMP_VAL    = 8'hC5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] slotSel,
  output logic       sdaOe,
  output logic       csumOk
);
  localparam int DATA_W = 8;
  localparam int PTR_W  = $clog2(DEPTH);

  logic              sclSync, sdaSync, isProt;
  logic [DATA_W-1:0] rdByte, wrByte;
  logic [PTR_W-1:0]  curPtr;
  spdStrobe_t        strobe;

  spdSync #(.STAGES(SYNC_STAGES)) uSclSync (.clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync));
  spdSync #(.STAGES(SYNC_STAGES)) uSdaSync (.clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaSync));

  spdCtrl #(.DATA_W(DATA_W), .SLOT_W(3), .TEMP_EN(TEMP_EN), .TEMP_VAL(TEMP_VAL)) uCtrl (
    .clk(clk), .rstN(rstN), .scl(sclSync), .sda(sdaSync), .slotSel(slotSel),
    .isProt(isProt), .rdByte(rdByte), .sdaOe(sdaOe), .strobe(strobe), .wrByte(wrByte)
  );

  spdData #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CSUM_POS(63)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(wrByte), .rdByte(rdByte),
    .curPtr(curPtr), .isProt(isProt), .csumOk(csumOk)
  );
endmodule

// File: rtl/spdCheck.sv
module spdCheck
  import spdPkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input spdStrobe_t       strobe,
  input logic [7:0]       wrByte,
  input logic [PTR_W-1:0] curPtr,
  input logic             isProt
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  p_load_ptr_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPtr |=> curPtr == $past(wrByte[PTR_W-1:0]));

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepPtr || strobe.storeByte) |=> curPtr == PTR_W'($past(curPtr) + 1'b1));

  p_prot_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    isProt |=> isProt);

  p_prot_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!isProt && !strobe.setProt) |=> !isProt);
endmodule

bind spdTarget spdCheck #(.PTR_W(PTR_W)) uCheck (
  .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(wrByte), .curPtr(curPtr), .isProt(isProt)
);

// File: tb/spdTarget_test.sv
module spdTarget_test;
  localparam int Q = 8;
  localparam logic [7:0] TEMP_V = 8'hC5;
  localparam logic [2:0] SLOT = 3'b101;
  localparam logic [6:0] ARR = {4'b1010, SLOT};
  localparam logic [6:0] PRT = {4'b0011, SLOT};
  localparam logic [6:0] TMP = {4'b0001, SLOT};

  logic clk = 1'b0, rstN = 1'b0, mScl = 1'b1, mSda = 1'b1;
  logic sdaOe, csumOk;
  wire  sdaBus = mSda & ~sdaOe;

  int compared = 0, mismatched = 0;
  bit watchRelease = 1'b0, done = 1'b0;
  logic [7:0] model [256];
  int mPtr = 0;
  bit mProt = 1'b0;
  logic [7:0] payload [$];

  always #4 clk = ~clk;

  spdTarget #(.TEMP_VAL(TEMP_V)) uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .slotSel(SLOT),
    .sdaOe(sdaOe), .csumOk(csumOk)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 R10: released data line after refusal or master NACK
  always @(negedge clk) if (watchRelease) checkEq("R2/R10 release", sdaOe, 0);

  task automatic qwait(); repeat (Q) @(negedge clk); endtask
  task automatic busStart(); mSda = 1; qwait(); mScl = 1; qwait(); mSda = 0; qwait(); mScl = 0; qwait(); endtask
  task automatic busStop(); mSda = 0; qwait(); mScl = 1; qwait(); mSda = 1; qwait(); endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; qwait(); mScl = 1; qwait(); qwait(); mScl = 0; qwait();
    end
    mSda = 1; qwait(); mScl = 1; qwait(); acked = (sdaBus == 1'b0); qwait(); mScl = 0; qwait();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1; qwait(); mScl = 1; qwait(); b[i] = sdaBus; qwait(); mScl = 0; qwait();
    end
    mSda = ~giveAck; qwait(); mScl = 1; qwait(); qwait(); mScl = 0; qwait(); mSda = 1;
  endtask

  function automatic bit expectAck(input logic [6:0] dev);
    if (dev[2:0] != SLOT) return 0;
    return dev[6:3] == 4'b1010 || (dev[6:3] == 4'b0011 && !mProt) || dev[6:3] == 4'b0001;
  endfunction

  task automatic doWrite(input logic [6:0] dev, input string req);
    bit ack, exp;
    exp = expectAck(dev);
    busStart();
    sendByte({dev, 1'b0}, ack);
    checkEq({req, " address ack"}, ack, exp);
    if (exp && dev[6:3] == 4'b0011) mProt = 1;
    if (!exp) watchRelease = 1;
    foreach (payload[k]) begin
      sendByte(payload[k], ack);
      checkEq({req, " data ack"}, ack, exp);
      if (exp && dev[6:3] == 4'b1010) begin
        if (k == 0) mPtr = payload[k];
        else begin
          if (!mProt) model[mPtr] = payload[k];
          mPtr = (mPtr + 1) % 256;
        end
      end
    end
    busStop();
    watchRelease = 0;
  endtask

  task automatic readBody(input logic [6:0] dev, input int n, input string req);
    bit ack;
    logic [7:0] b, exp;
    busStart();
    sendByte({dev, 1'b1}, ack);
    checkEq({req, " read address ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      if (dev[6:3] == 4'b1010) begin exp = model[mPtr]; mPtr = (mPtr + 1) % 256; end
      else exp = TEMP_V;
      checkEq({req, " read data"}, b, exp);
    end
    checkEq("R10 released after NACK", sdaOe, 0);
    watchRelease = 1;
    busStop();
    watchRelease = 0;
  endtask

  task automatic randRead(input logic [7:0] p, input int n, input string req);
    bit ack;
    busStart();
    sendByte({ARR, 1'b0}, ack); checkEq({req, " addr ack"}, ack, 1);
    sendByte(p, ack);           checkEq({req, " ptr ack"}, ack, 1);
    mPtr = p;
    readBody(ARR, n, req);
  endtask

  task automatic checkSum(input string req);
    int s = 0;
    repeat (100) @(negedge clk);
    for (int i = 0; i < 63; i++) s += model[i];
    checkEq(req, csumOk, ((s & 255) == model[63]) ? 1 : 0);
  endtask

  initial begin
    int s;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    checkEq("R1 sdaOe in reset", sdaOe, 0);
    checkEq("R1 csumOk in reset", csumOk, 0);
    rstN = 1;
    repeat (100) @(negedge clk);
    checkEq("R1 csumOk after reset", csumOk, 1);
    checkEq("R1 sdaOe idle", sdaOe, 0);

    payload = '{8'h10, 8'hAA, 8'hBB, 8'hCC};
    doWrite(ARR, "R3 write");
    checkSum("R9 broken sum");
    randRead(8'h10, 3, "R4 random read");
    readBody(ARR, 2, "R5 current read");

    payload = '{8'h01, 8'h02};
    doWrite({4'b1010, 3'b010}, "R2 wrong slot");
    doWrite({4'b0110, SLOT}, "R2 unknown type");
    randRead(8'h00, 3, "R2 untouched");

    payload = '{8'hFE, 8'h11, 8'h22, 8'h33};
    doWrite(ARR, "R6 wrap write");
    randRead(8'hFE, 3, "R6 wrap read");

    s = 0;
    for (int i = 0; i < 63; i++) s += model[i];
    payload = '{8'h3F, 8'(s)};
    doWrite(ARR, "R9 fix sum");
    checkSum("R9 fixed sum");

    readBody(TMP, 2, "R8 sensor");

    payload = '{};
    doWrite(PRT, "R7 protect");
    payload = '{8'h20, 8'h77};
    doWrite(ARR, "R7 protected write");
    randRead(8'h20, 1, "R7 frozen");
    checkSum("R9 after protected write");
    payload = '{};
    doWrite(PRT, "R7 protect refused");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule